// File: doc/BRIEF.md
# Round-Robin Watermark Queue Dispatcher

This block hands out incoming code blocks to a bank of hardware queues. Two input FIFOs feed it, one carrying uplink work and one carrying downlink work. The bank is split in half. The lower half of the queue indices takes uplink blocks and the upper half takes downlink blocks. For each direction, the dispatcher looks at every queue of that half. A queue is eligible when software has marked it valid and its fill count is below that direction's watermark. The dispatcher picks the next eligible queue in circular order and pops one block from the matching FIFO into it.

When no queue of a direction is eligible, that direction's FIFO is not popped, so it holds back. Software programs the block through a simple write port. It writes one map word per queue, a watermark word holding a level for each direction, and an enable flag. Dispatch stays off until the enable flag is set. A completion port reports each block that a queue has finished, which lowers that queue's fill count.

Top module: `cbdisp_top`

## Requirements
- R1: After reset no pop is issued, every queue is unmapped, every fill count is zero and dispatch is disabled.
- R2: Dispatch runs only while enabled. A write whose byte address is 0x104 enables dispatch when data bits [7:0] equal 1 and disables it for any other value. While dispatch is disabled neither FIFO is popped.
- R3: A write to byte address 4×q (q from 0 to 63) sets the map entry of queue q. Data bit 0 is its valid flag; the other bits, including the owner field in bits [23:16], do not affect dispatch. A queue whose bit 0 is clear is never chosen. Uplink grants always name queues 0–31 and downlink grants always name queues 32–63.
- R4: Within each direction the search starts at the queue after the last one granted in that direction and wraps from the top of the half back to its bottom. After reset the search starts at the bottom of the half.
- R5: A write to byte address 0x100 sets the uplink watermark from data bits [7:0] and the downlink watermark from bits [15:8]. A queue whose fill count is at or above its direction's watermark is not chosen.
- R6: A FIFO is popped only when its valid input is high and at least one queue of its direction is eligible; otherwise its pop output stays low.
- R7: Each queue's fill count goes up by one on a grant and down by one on a completion. A grant and a completion to the same queue in the same cycle leave it unchanged. The count never goes below zero or above 255.
- R8: Uplink and downlink are dispatched independently, and both may be granted in the same cycle.
- R9: Pop and queue index respond in the same cycle as the FIFO valid input. Grants, completions and register writes affect eligibility from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 9 | Register byte address |
| cfgWrData | input | 32 | Register write data |
| ulValid | input | 1 | Uplink FIFO holds a code block |
| ulPop | output | 1 | Take one block from the uplink FIFO |
| ulQueue | output | 6 | Queue receiving the uplink block |
| dlValid | input | 1 | Downlink FIFO holds a code block |
| dlPop | output | 1 | Take one block from the downlink FIFO |
| dlQueue | output | 6 | Queue receiving the downlink block |
| cmplValid | input | 1 | One block finished in a queue |
| cmplQueue | input | 6 | Queue that finished the block |

## Verification
Pop and queue index are combinational in the FIFO valid input and the registered state. They are therefore due in the same cycle the valid input is driven. Grants, completions and writes change state at the following rising edge and can only show up in the next cycle's decision. The bench drives every input just after the falling edge and samples the outputs one nanosecond later. It compares them against a behavioural model of queue fill counts and search pointers. It then advances that model by exactly what the coming rising edge commits, so each comparison sees the state the design holds in that cycle.

// File: rtl/cbdisp_pkg.sv
package cbdisp_pkg;
  parameter int NUM_Q  = 64;
  parameter int OCC_W  = 8;
  parameter int ADDR_W = 9;
  localparam int HALF   = NUM_Q / 2;
  localparam int IDX_W  = $clog2(NUM_Q);
  localparam int HALF_W = $clog2(HALF);
  localparam int NUM_DIR = 2;
  localparam logic [ADDR_W-1:0] WM_ADDR   = ADDR_W'(NUM_Q * 4);
  localparam logic [ADDR_W-1:0] DONE_ADDR = ADDR_W'(NUM_Q * 4 + 4);

  typedef struct packed {
    logic [NUM_DIR-1:0]            grant;
    logic [NUM_DIR-1:0][IDX_W-1:0] idx;
  } grantStrobe_t;
endpackage

// File: rtl/cbdisp_dpath.sv
module cbdisp_dpath
  import cbdisp_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWrEn,
  input  logic [ADDR_W-1:0]           cfgAddr,
  input  logic [31:0]                 cfgWrData,
  input  logic                        cmplValid,
  input  logic [IDX_W-1:0]            cmplQueue,
  input  grantStrobe_t                strobe,
  output logic [NUM_Q-1:0]            eligible,
  output logic [NUM_Q-1:0]            mapValid,
  output logic [NUM_Q-1:0][OCC_W-1:0] occ,
  output logic [2*OCC_W-1:0]          wmReg,
  output logic                        ready
);
  localparam logic [OCC_W-1:0] OCC_MAX = '1;

  logic mapWr;
  logic unusedData;
  assign mapWr      = cfgWrEn && !cfgAddr[ADDR_W-1];
  assign unusedData = ^cfgWrData[31:2*OCC_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wmReg <= '0;
      ready <= 1'b0;
    end else if (cfgWrEn) begin
      if (cfgAddr == WM_ADDR)   wmReg <= cfgWrData[2*OCC_W-1:0];
      if (cfgAddr == DONE_ADDR) ready <= (cfgWrData[7:0] == 8'd1);
    end
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic             inc, dec, vBit;
    logic [OCC_W-1:0] cnt, lvl;

    assign inc = (strobe.grant[0] && strobe.idx[0] == IDX_W'(q)) ||
                 (strobe.grant[1] && strobe.idx[1] == IDX_W'(q));
    assign dec = cmplValid && (cmplQueue == IDX_W'(q));
    assign lvl = (q < HALF) ? wmReg[OCC_W-1:0] : wmReg[2*OCC_W-1:OCC_W];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt  <= '0;
        vBit <= 1'b0;
      end else begin
        if (inc && !dec && cnt != OCC_MAX) cnt <= cnt + 1'b1;
        else if (dec && !inc && cnt != '0) cnt <= cnt - 1'b1;
        if (mapWr && cfgAddr[IDX_W+1:2] == IDX_W'(q)) vBit <= cfgWrData[0];
      end
    end

    assign occ[q]      = cnt;
    assign mapValid[q] = vBit;
    assign eligible[q] = vBit && (cnt < lvl);
  end
endmodule

// File: rtl/cbdisp_ctrl.sv
module cbdisp_ctrl
  import cbdisp_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               ready,
  input  logic [NUM_DIR-1:0] reqValid,
  input  logic [NUM_Q-1:0]   eligible,
  output grantStrobe_t       strobe
);
  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    logic [HALF_W-1:0]   ptr, sel, off;
    logic [HALF-1:0]     elig, rot;
    logic [2*HALF-1:0]   doubled;
    logic [HALF_W:0]     shiftAmt;
    logic                found, grant;

    assign elig     = eligible[d*HALF +: HALF];
    assign doubled  = {elig, elig};
    assign shiftAmt = {1'b0, ptr} + 1'b1;
    assign rot      = HALF'(doubled >> shiftAmt);

    always_comb begin
      found = 1'b0;
      off   = '0;
      for (int k = 0; k < HALF; k++) begin
        if (!found && rot[k]) begin
          found = 1'b1;
          off   = HALF_W'(k);
        end
      end
    end

    assign sel   = ptr + 1'b1 + off;
    assign grant = ready && reqValid[d] && found;

    always_ff @(posedge clk) begin
      if (!rstN) ptr <= HALF_W'(HALF - 1);
      else if (grant) ptr <= sel;
    end

    assign strobe.grant[d] = grant;
    assign strobe.idx[d]   = IDX_W'(d * HALF) + IDX_W'(sel);
  end
endmodule

// File: rtl/cbdisp_top.sv
module cbdisp_top
  import cbdisp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [31:0]       cfgWrData,
  input  logic              ulValid,
  output logic              ulPop,
  output logic [IDX_W-1:0]  ulQueue,
  input  logic              dlValid,
  output logic              dlPop,
  output logic [IDX_W-1:0]  dlQueue,
  input  logic              cmplValid,
  input  logic [IDX_W-1:0]  cmplQueue
);
  grantStrobe_t                strobe;
  logic [NUM_Q-1:0]            eligible, mapValid;
  logic [NUM_Q-1:0][OCC_W-1:0] occ;
  logic [2*OCC_W-1:0]          wmReg;
  logic                        ready;

  cbdisp_dpath u_dpath (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cmplValid(cmplValid), .cmplQueue(cmplQueue),
    .strobe(strobe), .eligible(eligible), .mapValid(mapValid), .occ(occ),
    .wmReg(wmReg), .ready(ready)
  );

  cbdisp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ready(ready), .reqValid({dlValid, ulValid}),
    .eligible(eligible), .strobe(strobe)
  );

  assign ulPop   = strobe.grant[0];
  assign ulQueue = strobe.idx[0];
  assign dlPop   = strobe.grant[1];
  assign dlQueue = strobe.idx[1];
endmodule

// File: rtl/cbdisp_chk.sv
module cbdisp_chk
  import cbdisp_pkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic                        cfgWrEn,
  input logic [ADDR_W-1:0]           cfgAddr,
  input logic [31:0]                 cfgWrData,
  input logic                        ulValid,
  input logic                        ulPop,
  input logic [IDX_W-1:0]            ulQueue,
  input logic                        dlValid,
  input logic                        dlPop,
  input logic [IDX_W-1:0]            dlQueue,
  input logic [NUM_Q-1:0]            mapValid,
  input logic [NUM_Q-1:0][OCC_W-1:0] occ,
  input logic [2*OCC_W-1:0]          wmReg,
  input logic                        ready
);
  p_ul_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    ulPop |-> ulQueue < IDX_W'(HALF));
  p_dl_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    dlPop |-> dlQueue >= IDX_W'(HALF));
  p_mapped_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ulPop |-> mapValid[ulQueue]) and (dlPop |-> mapValid[dlQueue]));
  p_no_pop_disabled_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> (!ulPop && !dlPop));
  p_enable_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgAddr == DONE_ADDR && cfgWrData[7:0] == 8'd1) |=> ready);
  p_below_wm_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ulPop |-> occ[ulQueue] < wmReg[OCC_W-1:0]) and
    (dlPop |-> occ[dlQueue] < wmReg[2*OCC_W-1:OCC_W]));
  p_pop_needs_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ulPop |-> ulValid) and (dlPop |-> dlValid));
  p_occ_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (occ[0] == $past(occ[0])) || (occ[0] == $past(occ[0]) + OCC_W'(1)) ||
    (occ[0] == $past(occ[0]) - OCC_W'(1)));
endmodule

bind cbdisp_top cbdisp_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
  .cfgWrData(cfgWrData), .ulValid(ulValid), .ulPop(ulPop), .ulQueue(ulQueue),
  .dlValid(dlValid), .dlPop(dlPop), .dlQueue(dlQueue), .mapValid(mapValid),
  .occ(occ), .wmReg(wmReg), .ready(ready)
);

// File: tb/cbdisp_top_bench.sv
module cbdisp_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [8:0]  cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic        ulValid = 1'b0, dlValid = 1'b0, cmplValid = 1'b0;
  logic        ulPop, dlPop;
  logic [5:0]  ulQueue, dlQueue, cmplQueue = '0;

  always #10 clk = ~clk;

  cbdisp_top u_cbdisp_top (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .ulValid(ulValid), .ulPop(ulPop), .ulQueue(ulQueue),
    .dlValid(dlValid), .dlPop(dlPop), .dlQueue(dlQueue),
    .cmplValid(cmplValid), .cmplQueue(cmplQueue)
  );

  int    checks = 0, fails = 0;
  string curReq = "R1";
  bit    mMap[64];
  int    mOcc[64];
  int    mWm[2];
  int    mPtr[2];
  bit    mRdy;
  bit    finished = 1'b0;

  function automatic int pickQ(int dir, bit v);
    if (!mRdy || !v) return -1;
    for (int k = 1; k <= 32; k++) begin
      int q = dir * 32 + (mPtr[dir] + k) % 32;
      if (mMap[q] && mOcc[q] < mWm[dir]) return q;
    end
    return -1;
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic step(bit ulv, bit dlv, bit wr = 0, logic [8:0] a = 0,
                      logic [31:0] d = 0, bit cv = 0, logic [5:0] cq = 0);
    int eu, ed;
    @(negedge clk);
    ulValid = ulv; dlValid = dlv; cfgWrEn = wr; cfgAddr = a; cfgWrData = d;
    cmplValid = cv; cmplQueue = cq;
    #1;
    eu = pickQ(0, ulv);
    ed = pickQ(1, dlv);
    chk("ulPop", int'(ulPop), int'(eu >= 0));
    chk("dlPop", int'(dlPop), int'(ed >= 0));
    if (eu >= 0) chk("ulQueue", int'(ulQueue), eu);
    if (ed >= 0) chk("dlQueue", int'(dlQueue), ed);
    // commit what the rising edge will commit
    for (int q = 0; q < 64; q++) begin
      bit inc = (q == eu) || (q == ed);
      bit dec = cv && (int'(cq) == q);
      if (inc && !dec && mOcc[q] < 255) mOcc[q]++;
      else if (dec && !inc && mOcc[q] > 0) mOcc[q]--;
    end
    if (eu >= 0) mPtr[0] = eu;
    if (ed >= 0) mPtr[1] = ed - 32;
    if (wr) begin
      if (a[8] == 1'b0) mMap[a[7:2]] = d[0];
      else if (a == 9'h100) begin mWm[0] = d[7:0]; mWm[1] = d[15:8]; end
      else if (a == 9'h104) mRdy = (d[7:0] == 8'd1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    foreach (mMap[i]) begin mMap[i] = 0; mOcc[i] = 0; end
    mWm[0] = 0; mWm[1] = 0; mPtr[0] = 31; mPtr[1] = 31; mRdy = 0;
    // R1: outputs quiet during and after reset
    repeat (2) @(negedge clk);
    #1 chk("ulPop in reset", int'(ulPop), 0);
    @(negedge clk); rstN = 1'b1;
    curReq = "R1";
    repeat (3) step(1, 1);
    // R2: map and watermark programmed, dispatch not yet enabled
    curReq = "R2";
    step(1, 1, 1, 9'h000, 32'h0000_0001);
    step(1, 1, 1, 9'h004, 32'h0080_0001);
    step(1, 1, 1, 9'h008, 32'h0000_0001);
    step(1, 1, 1, 9'h014, 32'h0087_0001);
    step(1, 1, 1, 9'h07C, 32'h0000_0001);
    step(1, 1, 1, 9'h00C, 32'h0081_0000);   // R3: owner bits set, bit 0 clear
    step(1, 1, 1, 9'h080, 32'h0000_0001);
    step(1, 1, 1, 9'h0A0, 32'h0082_0001);
    step(1, 1, 1, 9'h0FC, 32'h0000_0001);
    step(1, 1, 1, 9'h100, 32'h0000_0102);   // R5: ul level 2, dl level 1
    step(1, 1);
    step(0, 0, 1, 9'h104, 32'h0000_0001);
    // R4: uplink walks 0,1,2,5,31, skipping unmapped 3
    curReq = "R4";
    repeat (5) step(1, 0);
    // R5: second round fills every uplink queue to level 2
    curReq = "R5";
    repeat (5) step(1, 0);
    // R6: all uplink queues at the watermark, no pop
    curReq = "R6";
    repeat (3) step(1, 0);
    // R8: downlink works alone and alongside uplink
    curReq = "R8";
    repeat (4) step(1, 1);
    // R7: drain queue 0 past zero, then it takes exactly two blocks
    curReq = "R7";
    repeat (4) step(0, 0, 0, 0, 0, 1, 6'd0);
    repeat (4) step(1, 0);
    step(1, 0, 0, 0, 0, 1, 6'd5);            // R9: completion seen next cycle
    step(1, 0);
    step(1, 1, 0, 0, 0, 1, 6'd40);
    step(1, 1);
    // R2: any value other than 1 disables, 1 re-enables
    curReq = "R2";
    step(1, 1, 1, 9'h104, 32'h0000_0002);
    step(0, 0, 0, 0, 0, 1, 6'd1);
    step(1, 1);
    step(1, 1, 1, 9'h104, 32'h0000_0001);
    step(1, 1);
    // R3: remap queue 3 valid, unmap 1
    curReq = "R3";
    step(0, 0, 1, 9'h00C, 32'h0080_0001);
    step(0, 0, 1, 9'h004, 32'h0000_0000);
    repeat (6) step(0, 0, 0, 0, 0, 1, 6'd2);
    repeat (4) step(1, 0);
    // R5: level 0 stops everything
    curReq = "R5";
    step(1, 1, 1, 9'h100, 32'h0000_0000);
    repeat (2) step(1, 1);
    // R9: mixed traffic
    curReq = "R9";
    step(0, 0, 1, 9'h100, 32'h0000_0304);
    for (int i = 0; i < 64; i += 3) step(0, 0, 1, 9'(i * 4), 32'h1);
    for (int n = 0; n < 600; n++) begin
      int r = $urandom_range(0, 19);
      if (r == 0) step($urandom_range(0,1), $urandom_range(0,1), 1,
                       9'($urandom_range(0, 63) * 4), 32'($urandom_range(0,1)));
      else step($urandom_range(0,1), $urandom_range(0,1), 0, 0, 0,
                $urandom_range(0,1), 6'($urandom_range(0,63)));
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule